// File: doc/BRIEF.md
# DRAM Rank Power-State and Refresh Sequencer

This block follows the power state of one DRAM rank and runs its periodic auto-refresh. The scheduler in front of it reports each bank activate, together with the cycle at which it takes effect and the cycle at which its minimum row-open time ends. It also reports each precharge together with the cycle at which that precharge completes. The block counts open banks. It moves a power-state machine between all-banks-idle, active and refreshing, and accumulates the cycles spent in each state so that a power estimator can read them.

A second machine tracks refresh. When a refresh falls due, the block either starts it at once, if the rank is already idle, or closes every open row and waits for the last of those precharges to complete. It then holds off new commands for the refresh duration and releases them again. The two machines are coupled. The refresh machine waits for the power machine to reach the idle state. When the rank becomes idle while a refresh is waiting, the power machine goes straight into refresh in the same cycle.

Times are absolute values of a free-running cycle counter supplied on `cyc_now`. The precharge time, refresh duration and refresh interval are parameters (`T_RP`, `T_RFC`, `T_REFI`).

Top module: `dram_pwr_seq`

## Requirements
- R1: `pstate` encodes idle as 0, refreshing as 1 and active as 3. Codes 2 and 4 are reserved for power-down modes, never appear, and their residency counters stay 0. `rstate` encodes waiting as 0, closing as 1 and refresh-running as 2.
- R2: An activate that takes effect at cycle T makes `pstate` read active from cycle T+1, when it was not already active.
- R3: The move from active to idle is decided at the completion cycle of the latest outstanding precharge, and happens only if no bank is open at that cycle. An activate accepted before then cancels the move.
- R4: When a refresh starts, `rstate` reads closing for exactly one cycle and then refresh-running. Every open row is closed in that cycle, so `open_banks` reads 0 afterwards.
- R5: A row closed for refresh completes at the largest of its activate time, its row-open-time end and the current cycle, plus `T_RP`.
- R6: When the rank is idle with no open bank as a refresh starts, `pstate` reads refreshing in the cycle after closing, and no precharge is issued.
- R7: When the last forced precharge completes during refresh-running, `pstate` goes from active straight to refreshing, and the idle residency does not change.
- R8: A refresh lasts `T_RFC` cycles. After it, `pstate` reads idle, `rstate` reads waiting and `issue_hold` drops. `issue_hold` is high whenever `rstate` is not waiting, and activates and precharges presented while it is high are ignored.
- R9: The first refresh starts at cycle `T_REFI-T_RP`. Each later refresh starts at the previous due time plus `T_REFI` minus `T_RP`, and the due time advances by `T_REFI` each time a refresh is entered.
- R10: On every `pstate` change, the cycles spent in the state being left are added to that state's counter in `resid_flat`. State s occupies bits [s*CW +: CW], and each counter saturates at its maximum.
- R11: Only the refresh-exit transition can be pending. A power transition requested while it is pending, or two transitions requested in one cycle, set the sticky `trans_err`. The pending transition wins and the new request is dropped.
- R12: After reset, `pstate`, `rstate`, `open_banks`, `issue_hold`, `trans_err` and all residency counters read 0.
- R13: An activate to a closed bank adds one to `open_banks`. A precharge to an open bank removes one. Commands to a bank in the wrong state are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cyc_now | input | TW | Free-running cycle count |
| act_vld | input | 1 | Activate command present |
| act_bank | input | log2(NBANK) | Bank of the activate |
| act_time | input | TW | Cycle at which the activate takes effect |
| act_ras_time | input | TW | Cycle at which the row may first be closed |
| pre_vld | input | 1 | Precharge command present |
| pre_bank | input | log2(NBANK) | Bank of the precharge |
| pre_time | input | TW | Cycle at which the precharge completes |
| issue_hold | output | 1 | New commands are blocked |
| pstate | output | 3 | Power state |
| rstate | output | 2 | Refresh state |
| open_banks | output | log2(NBANK+1) | Number of open banks |
| resid_flat | output | 5*CW | Per-state residency counters |
| trans_err | output | 1 | Sticky conflicting-transition flag |

## Verification
The bench runs several directed timelines against the power and refresh machines. An activate followed by a precharge shows when the move to active happens and when the move to idle happens. An overlapping activate shows that a later open cancels a pending move to idle. Three refreshes are then exercised. The first starts from an idle rank, which separates the immediate-entry path from the close-then-wait path. The second starts with a row whose open-time end dominates, which checks the completion formula and the zero-time active-to-refresh step. The third holds an activate that fires during refresh, which raises the conflict flag. A seeded random phase then issues activates and precharges at random times across further refresh intervals. In every cycle it compares the open-bank count with a bench model, and it compares each residency counter with cycle counts derived from the observed state changes.

// File: rtl/dram_pwr_seq.sv
module dram_pwr_seq #(
  parameter int NBANK  = 8,
  parameter int TW     = 32,
  parameter int CW     = 32,
  parameter int T_RP   = 4,
  parameter int T_RFC  = 20,
  parameter int T_REFI = 400,
  localparam int BW    = (NBANK > 1) ? $clog2(NBANK) : 1,
  localparam int NW    = $clog2(NBANK + 1)
)(
  input  logic              clk,
  input  logic              rst,
  input  logic [TW-1:0]     cyc_now,
  input  logic              act_vld,
  input  logic [BW-1:0]     act_bank,
  input  logic [TW-1:0]     act_time,
  input  logic [TW-1:0]     act_ras_time,
  input  logic              pre_vld,
  input  logic [BW-1:0]     pre_bank,
  input  logic [TW-1:0]     pre_time,
  output logic              issue_hold,
  output logic [2:0]        pstate,
  output logic [1:0]        rstate,
  output logic [NW-1:0]     open_banks,
  output logic [5*CW-1:0]   resid_flat,
  output logic              trans_err
);
  localparam int NPS = 5;
  localparam logic [2:0] PS_IDLE = 3'd0, PS_REF = 3'd1, PS_ACT = 3'd3;
  localparam logic [1:0] RS_WAIT = 2'd0, RS_CLOSE = 2'd1, RS_RUN = 2'd2;
  localparam logic [TW-1:0] RP_T   = TW'(T_RP);
  localparam logic [TW-1:0] RFC_T  = TW'(T_RFC);
  localparam logic [TW-1:0] REFI_T = TW'(T_REFI);

  logic [NBANK-1:0] bk_open;
  logic [TW-1:0]    bk_free [NBANK];
  logic [TW-1:0]    bk_ras  [NBANK];
  logic [TW-1:0]    done_t  [NBANK];
  logic [TW-1:0]    close_max;
  logic             any_open;

  logic [NW-1:0] cnt;
  logic          act_ok, pre_ok, ref_close;

  logic          act_pend, pre_pend, ptr_pend;
  logic [TW-1:0] act_at, pre_at, ptr_at;
  logic          act_due, pre_due, ptr_fire;

  logic [2:0]    pwr;
  logic [1:0]    rs;
  logic [TW-1:0] ent, ref_at, ref_due;
  logic [CW-1:0] res [NPS];

  logic          quiet, ref_req, pre_req, act_req, clash, go;
  logic [1:0]    nreq;
  logic [2:0]    tgt, fin;
  logic [CW-1:0] dur_c;
  logic [CW:0]   sum_w;

  assign issue_hold = (rs != RS_WAIT);
  assign act_ok     = act_vld && !issue_hold && !bk_open[act_bank];
  assign pre_ok     = pre_vld && !issue_hold &&  bk_open[pre_bank];
  assign quiet      = (pwr == PS_IDLE) && (cnt == '0);
  assign ref_close  = (rs == RS_CLOSE) && !quiet;

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    logic [TW-1:0] m1;
    assign m1 = (bk_free[g] > bk_ras[g]) ? bk_free[g] : bk_ras[g];
    assign done_t[g] = ((m1 > cyc_now) ? m1 : cyc_now) + RP_T;
  end

  always_comb begin
    close_max = '0;
    any_open  = 1'b0;
    for (int i = 0; i < NBANK; i++)
      if (bk_open[i]) begin
        any_open = 1'b1;
        if (done_t[i] > close_max) close_max = done_t[i];
      end
  end

  always_ff @(posedge clk) begin
    if (rst) bk_open <= '0;
    else if (ref_close) bk_open <= '0;
    else begin
      if (act_ok) begin
        bk_open[act_bank] <= 1'b1;
        bk_free[act_bank] <= act_time;
        bk_ras[act_bank]  <= act_ras_time;
      end
      if (pre_ok) bk_open[pre_bank] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else if (ref_close) cnt <= '0;
    else cnt <= cnt + NW'(act_ok) - NW'(pre_ok);
  end

  assign act_due  = act_pend && (cyc_now >= act_at);
  assign pre_due  = pre_pend && (cyc_now >= pre_at);
  assign ptr_fire = ptr_pend && (cyc_now >= ptr_at);

  always_ff @(posedge clk) begin
    if (rst) act_pend <= 1'b0;
    else begin
      if (act_due) act_pend <= 1'b0;
      if (act_ok) begin
        act_pend <= 1'b1;
        act_at   <= (act_pend && !act_due && act_at < act_time) ? act_at : act_time;
      end
    end
  end

  logic          pnew_v;
  logic [TW-1:0] pnew_t;
  assign pnew_v = pre_ok || (ref_close && any_open);
  assign pnew_t = pre_ok ? pre_time : close_max;

  always_ff @(posedge clk) begin
    if (rst) pre_pend <= 1'b0;
    else begin
      if (pre_due) pre_pend <= 1'b0;
      if (pnew_v) begin
        pre_pend <= 1'b1;
        pre_at   <= (pre_pend && !pre_due && pre_at > pnew_t) ? pre_at : pnew_t;
      end
    end
  end

  assign ref_req = (rs == RS_CLOSE) && quiet;
  assign pre_req = pre_due && (cnt == '0) && (pwr == PS_ACT);
  assign act_req = act_due && (pwr != PS_ACT);
  assign nreq    = 2'(ref_req) + 2'(pre_req) + 2'(act_req);
  assign clash   = (nreq > 2'd1) || (ptr_pend && nreq != 2'd0);

  always_comb begin
    go  = 1'b1;
    tgt = PS_IDLE;
    if (ptr_fire)      tgt = PS_IDLE;
    else if (ptr_pend) go  = 1'b0;
    else if (ref_req)  tgt = PS_REF;
    else if (pre_req)  tgt = PS_IDLE;
    else if (act_req)  tgt = PS_ACT;
    else               go  = 1'b0;
  end

  assign fin   = (tgt == PS_IDLE && pwr == PS_ACT && rs == RS_RUN) ? PS_REF : tgt;
  assign dur_c = CW'(cyc_now - ent);
  assign sum_w = {1'b0, res[pwr]} + {1'b0, dur_c};

  always_ff @(posedge clk) begin
    if (rst) begin
      pwr <= PS_IDLE;
      ent <= cyc_now;
      for (int s = 0; s < NPS; s++) res[s] <= '0;
    end else if (go) begin
      pwr      <= fin;
      ent      <= cyc_now;
      res[pwr] <= sum_w[CW] ? '1 : sum_w[CW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ptr_pend <= 1'b0;
    else if (go && fin == PS_REF) begin
      ptr_pend <= 1'b1;
      ptr_at   <= cyc_now + RFC_T;
    end else if (ptr_fire) ptr_pend <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) trans_err <= 1'b0;
    else if (clash) trans_err <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rs      <= RS_WAIT;
      ref_at  <= REFI_T - RP_T;
      ref_due <= REFI_T;
    end else begin
      case (rs)
        RS_WAIT:  if (cyc_now >= ref_at) rs <= RS_CLOSE;
        RS_CLOSE: rs <= RS_RUN;
        default:  if (go && pwr == PS_REF) rs <= RS_WAIT;
      endcase
      if (go && fin == PS_REF) begin
        ref_at  <= ref_due + REFI_T - RP_T;
        ref_due <= ref_due + REFI_T;
      end
    end
  end

  for (genvar s = 0; s < NPS; s++) begin : g_res
    assign resid_flat[s*CW +: CW] = res[s];
  end

  assign pstate     = pwr;
  assign rstate     = rs;
  assign open_banks = cnt;
endmodule

// File: rtl/dram_pwr_seq_chk.sv
module dram_pwr_seq_chk #(
  parameter int NBANK = 8,
  parameter int NW    = 4
)(
  input logic          clk,
  input logic          rst,
  input logic [2:0]    pstate,
  input logic [1:0]    rstate,
  input logic          issue_hold,
  input logic [NW-1:0] open_banks,
  input logic          trans_err
);
  // R1
  never_pdn_chk: assert property (@(posedge clk) disable iff (rst)
    pstate != 3'd2 && pstate != 3'd4);
  // R8
  ref_hold_chk: assert property (@(posedge clk) disable iff (rst)
    pstate == 3'd1 |-> issue_hold);
  // R8
  hold_closed_chk: assert property (@(posedge clk) disable iff (rst)
    issue_hold |=> open_banks == '0);
  // R4
  close_once_chk: assert property (@(posedge clk) disable iff (rst)
    rstate == 2'd1 |=> rstate == 2'd2);
  // R7
  run_act_chk: assert property (@(posedge clk) disable iff (rst)
    rstate == 2'd2 && pstate == 3'd3 |=> pstate != 3'd0);
  // R11
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    trans_err |=> trans_err);
  // R13
  count_bound_chk: assert property (@(posedge clk) disable iff (rst)
    open_banks <= NW'(NBANK));
endmodule

bind dram_pwr_seq dram_pwr_seq_chk #(.NBANK(NBANK), .NW(NW)) chk_i (
  .clk(clk), .rst(rst), .pstate(pstate), .rstate(rstate),
  .issue_hold(issue_hold), .open_banks(open_banks), .trans_err(trans_err)
);

// File: tb/dram_pwr_seq_tb_top.sv
module dram_pwr_seq_tb_top;
  localparam int NB = 8, CW = 32, RP = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst = 1'b1;
  logic [31:0] cyc_now;
  logic        act_vld = 1'b0, pre_vld = 1'b0;
  logic [2:0]  act_bank = '0, pre_bank = '0;
  logic [31:0] act_time = '0, act_ras_time = '0, pre_time = '0;
  logic        issue_hold, trans_err;
  logic [2:0]  pstate;
  logic [1:0]  rstate;
  logic [3:0]  open_banks;
  logic [5*CW-1:0] resid_flat;

  int nchk = 0, nfail = 0;
  bit done = 0;
  bit m_open [NB];
  int unsigned m_at [NB];
  int unsigned exp_res [5];
  int prev_ps = 0;
  int unsigned ent = 0;
  int unsigned saved;

  dram_pwr_seq dut_i (
    .clk(clk), .rst(rst), .cyc_now(cyc_now),
    .act_vld(act_vld), .act_bank(act_bank), .act_time(act_time), .act_ras_time(act_ras_time),
    .pre_vld(pre_vld), .pre_bank(pre_bank), .pre_time(pre_time),
    .issue_hold(issue_hold), .pstate(pstate), .rstate(rstate),
    .open_banks(open_banks), .resid_flat(resid_flat), .trans_err(trans_err)
  );

  always_ff @(posedge clk)
    if (rst) cyc_now <= '0;
    else     cyc_now <= cyc_now + 1;

  function automatic int unsigned res_of(int s);
    return resid_flat[s*CW +: CW];
  endfunction

  function automatic int unsigned model_cnt();
    int unsigned n = 0;
    for (int i = 0; i < NB; i++) n += m_open[i];
    return n;
  endfunction

  task automatic check(string tag, int unsigned got, int unsigned exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s at cycle %0d: got=%0d exp=%0d", tag, cyc_now, got, exp);
    end
  endtask

  task automatic observe();
    if (int'(pstate) != prev_ps) begin
      exp_res[prev_ps] += (cyc_now - 1) - ent;
      ent = cyc_now - 1;
      prev_ps = pstate;
    end
    check("R1 reserved state", (pstate == 3'd2 || pstate == 3'd4), 0);
    if (issue_hold) for (int i = 0; i < NB; i++) m_open[i] = 0;
    else check("R13 open_banks", open_banks, model_cnt());
    if (pstate == 3'd1) check("R8 hold during refresh", issue_hold, 1);
    for (int s = 0; s < 5; s++) check("R10 residency", res_of(s), exp_res[s]);
  endtask

  task automatic step();
    @(negedge clk);
    observe();
    act_vld = 1'b0;
    pre_vld = 1'b0;
  endtask

  task automatic go_to(int unsigned t);
    while (cyc_now < t) step();
  endtask

  task automatic do_act(int b, int unsigned t, int unsigned r);
    act_vld = 1'b1; act_bank = 3'(b); act_time = t; act_ras_time = r;
    if (!issue_hold && !m_open[b]) begin m_open[b] = 1; m_at[b] = t; end
  endtask

  task automatic do_pre(int b, int unsigned t);
    pre_vld = 1'b1; pre_bank = 3'(b); pre_time = t;
    if (!issue_hold && m_open[b]) m_open[b] = 0;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
  endtask

  initial begin
    int unsigned rnd;
    rnd = $urandom(32'd2024);
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R12 reset state
    check("R12 pstate", pstate, 0);
    check("R12 rstate", rstate, 0);
    check("R12 open_banks", open_banks, 0);
    check("R12 issue_hold", issue_hold, 0);
    check("R12 trans_err", trans_err, 0);
    for (int s = 0; s < 5; s++) check("R12 residency", res_of(s), 0);

    // R2 activate effect
    go_to(10); do_act(0, 13, 20);
    go_to(13); check("R2 before effect", pstate, 0);
    go_to(14); check("R2 active", pstate, 3);
    // R3 move to idle
    go_to(30); do_pre(0, 34);
    go_to(34); check("R3 still active", pstate, 3);
    go_to(35); check("R3 idle", pstate, 0);
    // R3 cancel by later activate
    go_to(40); do_act(0, 41, 44);
    go_to(45); do_pre(0, 52);
    go_to(47); do_act(1, 49, 50);
    go_to(53); check("R3 cancelled", pstate, 3);
    go_to(60); do_pre(1, 64);
    go_to(64); check("R3 active at completion", pstate, 3);
    go_to(65); check("R3 idle after last", pstate, 0);

    // R6 refresh from idle, R9 first start
    go_to(396); check("R9 waiting", rstate, 0);
    go_to(397); check("R9 first start", rstate, 1);
    check("R8 hold in close", issue_hold, 1);
    go_to(398); check("R6 immediate refresh", pstate, 1);
    check("R4 run", rstate, 2);
    go_to(405); do_act(4, 406, 410);
    go_to(407); check("R8 ignored open_banks", open_banks, 0);
    check("R8 ignored pstate", pstate, 1);
    go_to(417); check("R8 refresh ongoing", pstate, 1);
    go_to(418); check("R8 back idle", pstate, 0);
    check("R8 rstate waiting", rstate, 0);
    check("R8 hold released", issue_hold, 0);
    check("R8 refresh length", res_of(1), 20);

    // R5 R7 forced close with dominant row-open end
    go_to(780); do_act(2, 781, 805);
    go_to(782); check("R2 active", pstate, 3);
    saved = res_of(0);
    go_to(796); check("R9 waiting", rstate, 0);
    go_to(797); check("R9 second start", rstate, 1);
    go_to(798); check("R4 run", rstate, 2);
    check("R4 rows closed", open_banks, 0);
    check("R4 still active", pstate, 3);
    go_to(809); check("R5 before completion", pstate, 3);
    go_to(810); check("R7 straight to refresh", pstate, 1);
    check("R7 idle residency", res_of(0), saved);
    go_to(830); check("R8 idle after refresh", pstate, 0);

    // R11 activate firing during refresh
    go_to(1190); do_act(0, 1205, 1206);
    go_to(1191); do_pre(0, 1193);
    go_to(1196); check("R9 waiting", rstate, 0);
    go_to(1197); check("R9 third start", rstate, 1);
    go_to(1198); check("R6 immediate refresh", pstate, 1);
    go_to(1205); check("R11 no error yet", trans_err, 0);
    go_to(1206); check("R11 error set", trans_err, 1);
    check("R11 pending wins", pstate, 1);
    go_to(1218); check("R8 idle after refresh", pstate, 0);
    go_to(1230); check("R11 sticky", trans_err, 1);

    // random phase
    while (cyc_now < 9000) begin
      step();
      if (!issue_hold) begin
        int unsigned r, b;
        r = $urandom % 8;
        b = $urandom % NB;
        if (r < 2 && !m_open[b]) begin
          int unsigned t;
          t = cyc_now + ($urandom % 4);
          do_act(int'(b), t, t + ($urandom % 8));
        end else if (r < 4 && m_open[b] && m_at[b] + 1 < cyc_now)
          do_pre(int'(b), cyc_now + 1 + ($urandom % RP));
      end
    end
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL R8 watchdog: got=%0d exp=9000", cyc_now);
      summary();
      $finish;
    end
  end
endmodule